// File: doc/BRIEF.md
# DDR Read-Enable Latency Generator

This block sits in a DDR2 memory controller between the command scheduler and the pad register stage. Each read command it accepts is placed into a shift-register schedule. The block then raises a read strobe one cycle before the first data beat returns from memory, and raises a capture strobe for the read-data FIFO on every valid beat. The round-trip delay has two parts: a fixed part, made of the output and input pad register stages, and a programmable part, the CAS latency. The CAS latency is sampled together with each command, so a new setting takes effect without a drain and without disturbing reads already scheduled.

The block also registers the command and data-control buses on their way to the pads. Both buses go through one register stage, so they keep their relative cycle alignment. A permit output tells an external delay-locked loop when no read is in flight, so that the loop can update its delay without corrupting a capture.

Top module: `rd_en_latgen`

## Requirements
- R1: A read command sampled at clock edge E, with clamped CAS latency CL and the default pad delays (one output stage, one input stage), raises `read_en` in the cycle that follows edge E+CL+1. `read_en` therefore leads the first data beat by exactly one cycle.
- R2: `read_en` stays high for 4 consecutive cycles when `rd_bl8`=1 (burst of 8) and for 2 consecutive cycles when `rd_bl8`=0 (burst of 4).
- R3: `fifo_we` equals `read_en` delayed by one cycle, so it is high on each cycle that carries a valid data beat.
- R4: `cas_lat` is sampled only on the edge that accepts a read command. A change to `cas_lat` while reads are outstanding leaves their timing unchanged and applies only to later commands.
- R5: Values of `cas_lat` outside 3..6 are clamped: 0, 1 and 2 act as 3, and 7 acts as 6.
- R6: Several reads can be outstanding at once, at least four. Strobes from overlapping or back-to-back commands merge, so bursts of 8 issued four cycles apart give a continuous `read_en` with no gap.
- R7: `dll_upd_ok` is high in a cycle exactly when `read_en` and `fifo_we` are both low in that cycle and no read strobe is scheduled for a later cycle.
- R8: `pad_cmd` and `pad_dctl` show, one cycle later, `cmd_in` and `dctl_in` when their enables `cmd_en` and `dctl_en` were high. Otherwise they show zero. Both buses therefore keep the same alignment.
- R9: A synchronous active-high `rst` clears all scheduled reads. It drives `read_en`, `fifo_we`, `pad_cmd` and `pad_dctl` low and `dll_upd_ok` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_cmd | input | 1 | One-cycle read command pulse |
| rd_bl8 | input | 1 | Burst length of the command: 1 = 8 beats, 0 = 4 beats |
| cas_lat | input | CL_W | Programmed CAS latency |
| cmd_en | input | 1 | Command bus valid |
| cmd_in | input | CMD_W | Command bus toward the pads |
| dctl_en | input | 1 | Data-control bus valid |
| dctl_in | input | DCTL_W | Data-control bus toward the pads |
| read_en | output | 1 | Read strobe, one cycle ahead of the data |
| fifo_we | output | 1 | Read-data FIFO write enable |
| dll_upd_ok | output | 1 | Delay-line update permitted |
| pad_cmd | output | CMD_W | Registered command bus |
| pad_dctl | output | DCTL_W | Registered data-control bus |

## Verification
Two functions can land in the same cycle. The tail of one burst's strobe can coincide with the head of the next, and a new command can be accepted in the same edge in which the delay-line permit would otherwise rise. The bench provokes both cases. Directed bursts are spaced exactly one burst apart, four short reads are stacked one cycle apart at the longest latency, `cas_lat` is switched while reads are pending, and random commands arrive roughly every fourth cycle. A bench model derives, for every cycle, the expected strobe, write enable and permit. That model is built from the command history and the clamped latency, and every output is compared against it each cycle.

// File: rtl/rdlat_pkg.sv
package rdlat_pkg;

  // Burst length code carried with each read command
  typedef enum logic {
    BURST4 = 1'b0,
    BURST8 = 1'b1
  } burst_e;

  // Clamp a programmed latency into the supported window
  function automatic int clamp_lat(input logic [2:0] v, input int lo, input int hi);
    int x;
    x = int'(v);
    if (x < lo) return lo;
    if (x > hi) return hi;
    return x;
  endfunction

  // Number of strobe cycles for a burst (double data rate)
  function automatic int strobe_len(input burst_e b);
    return (b == BURST8) ? 4 : 2;
  endfunction

endpackage

// File: rtl/rdlat_sched.sv
module rdlat_sched
  import rdlat_pkg::*;
#(
  parameter int CL_W    = 3,
  parameter int CL_MIN  = 3,
  parameter int CL_MAX  = 6,
  parameter int OUT_DLY = 1,
  parameter int IN_DLY  = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue,
  input  logic            bl8,
  input  logic [CL_W-1:0] cas,
  output logic            re_q,
  output logic            busy_nxt
);

  localparam int DEPTH = CL_MAX + OUT_DLY + IN_DLY + 3;

  logic [DEPTH-1:0] sched_q;
  logic [DEPTH-1:0] mask;
  logic [DEPTH-1:0] sched_d;
  int               first;
  int               beats;

  always_comb begin
    first = clamp_lat(3'(cas), CL_MIN, CL_MAX) + OUT_DLY + IN_DLY - 1;
    beats = strobe_len(burst_e'(bl8));
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_mask
      assign mask[i] = issue && (i >= first) && (i < first + beats);
    end
  endgenerate

  assign sched_d  = (sched_q >> 1) | mask;
  assign busy_nxt = |sched_d;

  always_ff @(posedge clk) begin
    if (rst) sched_q <= '0;
    else     sched_q <= sched_d;
  end

  assign re_q = sched_q[0];

endmodule

// File: rtl/rdlat_capture.sv
module rdlat_capture (
  input  logic clk,
  input  logic rst,
  input  logic re,
  input  logic busy_nxt,
  output logic we_q,
  output logic ok_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q <= 1'b0;
      ok_q <= 1'b1;
    end else begin
      we_q <= re;
      ok_q <= !(busy_nxt || re);
    end
  end

endmodule

// File: rtl/rdlat_pad_regs.sv
module rdlat_pad_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) dout[b] <= 1'b0;
        else     dout[b] <= en & din[b];
      end
    end
  endgenerate

endmodule

// File: rtl/rd_en_latgen.sv
module rd_en_latgen #(
  parameter int CL_W    = 3,
  parameter int CL_MIN  = 3,
  parameter int CL_MAX  = 6,
  parameter int OUT_DLY = 1,
  parameter int IN_DLY  = 1,
  parameter int CMD_W   = 8,
  parameter int DCTL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_cmd,
  input  logic              rd_bl8,
  input  logic [CL_W-1:0]   cas_lat,
  input  logic              cmd_en,
  input  logic [CMD_W-1:0]  cmd_in,
  input  logic              dctl_en,
  input  logic [DCTL_W-1:0] dctl_in,
  output logic              read_en,
  output logic              fifo_we,
  output logic              dll_upd_ok,
  output logic [CMD_W-1:0]  pad_cmd,
  output logic [DCTL_W-1:0] pad_dctl
);

  logic busy_nxt;

  rdlat_sched #(
    .CL_W   (CL_W),
    .CL_MIN (CL_MIN),
    .CL_MAX (CL_MAX),
    .OUT_DLY(OUT_DLY),
    .IN_DLY (IN_DLY)
  ) u_sched (
    .clk     (clk),
    .rst     (rst),
    .issue   (rd_cmd),
    .bl8     (rd_bl8),
    .cas     (cas_lat),
    .re_q    (read_en),
    .busy_nxt(busy_nxt)
  );

  rdlat_capture u_cap (
    .clk     (clk),
    .rst     (rst),
    .re      (read_en),
    .busy_nxt(busy_nxt),
    .we_q    (fifo_we),
    .ok_q    (dll_upd_ok)
  );

  rdlat_pad_regs #(.W(CMD_W)) u_pad_cmd (
    .clk (clk),
    .rst (rst),
    .en  (cmd_en),
    .din (cmd_in),
    .dout(pad_cmd)
  );

  rdlat_pad_regs #(.W(DCTL_W)) u_pad_dctl (
    .clk (clk),
    .rst (rst),
    .en  (dctl_en),
    .din (dctl_in),
    .dout(pad_dctl)
  );

endmodule

// File: rtl/rd_en_latgen_chk.sv
module rd_en_latgen_chk #(
  parameter int CMD_W  = 8,
  parameter int DCTL_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_en,
  input logic [CMD_W-1:0]  cmd_in,
  input logic              dctl_en,
  input logic [DCTL_W-1:0] dctl_in,
  input logic              read_en,
  input logic              fifo_we,
  input logic              dll_upd_ok,
  input logic [CMD_W-1:0]  pad_cmd,
  input logic [DCTL_W-1:0] pad_dctl
);

  p_we_trails_re_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (fifo_we == $past(read_en)));

  p_burst_min_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(read_en) |=> read_en);

  p_dll_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    dll_upd_ok |-> (!read_en && !fifo_we));

  p_reset_idle_r9: assert property (@(posedge clk)
    rst |=> (!read_en && !fifo_we && dll_upd_ok && (pad_cmd == '0) && (pad_dctl == '0)));

  p_pad_align_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pad_cmd  == ($past(cmd_en)  ? $past(cmd_in)  : {CMD_W{1'b0}})) &&
              (pad_dctl == ($past(dctl_en) ? $past(dctl_in) : {DCTL_W{1'b0}}))));

endmodule

bind rd_en_latgen rd_en_latgen_chk #(.CMD_W(CMD_W), .DCTL_W(DCTL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_en    (cmd_en),
  .cmd_in    (cmd_in),
  .dctl_en   (dctl_en),
  .dctl_in   (dctl_in),
  .read_en   (read_en),
  .fifo_we   (fifo_we),
  .dll_upd_ok(dll_upd_ok),
  .pad_cmd   (pad_cmd),
  .pad_dctl  (pad_dctl)
);

// File: tb/rd_en_latgen_bench.sv
module rd_en_latgen_bench;

  localparam int CMD_W  = 8;
  localparam int DCTL_W = 4;
  localparam int NCYC   = 4096;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rd_cmd = 1'b0;
  logic              rd_bl8 = 1'b0;
  logic [2:0]        cas_lat = 3'd3;
  logic              cmd_en = 1'b0;
  logic [CMD_W-1:0]  cmd_in = '0;
  logic              dctl_en = 1'b0;
  logic [DCTL_W-1:0] dctl_in = '0;
  logic              read_en, fifo_we, dll_upd_ok;
  logic [CMD_W-1:0]  pad_cmd;
  logic [DCTL_W-1:0] pad_dctl;

  always #10 clk = ~clk;

  rd_en_latgen #(.CMD_W(CMD_W), .DCTL_W(DCTL_W)) u_rd_en_latgen (
    .clk(clk), .rst(rst), .rd_cmd(rd_cmd), .rd_bl8(rd_bl8), .cas_lat(cas_lat),
    .cmd_en(cmd_en), .cmd_in(cmd_in), .dctl_en(dctl_en), .dctl_in(dctl_in),
    .read_en(read_en), .fifo_we(fifo_we), .dll_upd_ok(dll_upd_ok),
    .pad_cmd(pad_cmd), .pad_dctl(pad_dctl)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  int    c = 0;
  int    last_end = -1;
  bit    exp_re [NCYC];
  bit    rst_edge [NCYC];
  logic [CMD_W-1:0]  exp_pc = '0;
  logic [DCTL_W-1:0] exp_pd = '0;
  string tag = "R9";
  logic [2:0] cur_cl = 3'd4;

  function automatic int b_lat(input logic [2:0] v);
    int x;
    x = int'(v);
    if (x < 3) x = 3;
    if (x > 6) x = 6;
    return x + 2;
  endfunction

  task automatic chkv(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", req, what, c, act, exp);
    end
  endtask

  task automatic check_cycle();
    bit e_we, e_dll;
    e_we  = (c > 0) && exp_re[c-1] && !rst_edge[c];
    e_dll = (last_end < c) && !e_we;
    chkv(tag,  "read_en",    32'(read_en),    32'(exp_re[c]));
    chkv("R3", "fifo_we",    32'(fifo_we),    32'(e_we));
    chkv("R7", "dll_upd_ok", 32'(dll_upd_ok), 32'(e_dll));
    chkv("R8", "pad_cmd",    32'(pad_cmd),    32'(exp_pc));
    chkv("R8", "pad_dctl",   32'(pad_dctl),   32'(exp_pd));
  endtask

  task automatic step(input bit rd, input bit b8, input logic [2:0] cl, input bit do_rst);
    int L, n;
    check_cycle();
    cmd_in  = CMD_W'($urandom);
    cmd_en  = 1'($urandom);
    dctl_in = DCTL_W'($urandom);
    dctl_en = 1'($urandom);
    rd_cmd  = rd;
    rd_bl8  = b8;
    cas_lat = cl;
    rst     = do_rst;
    if (do_rst) begin
      for (int k = c + 1; k < NCYC; k++) exp_re[k] = 1'b0;
      rst_edge[c+1] = 1'b1;
      last_end = -1;
      exp_pc = '0;
      exp_pd = '0;
    end else begin
      exp_pc = cmd_en  ? cmd_in  : '0;
      exp_pd = dctl_en ? dctl_in : '0;
      if (rd) begin
        L = b_lat(cl);
        n = b8 ? 4 : 2;
        for (int k = 0; k < n; k++) exp_re[c + L + k] = 1'b1;
        if (c + L + n - 1 > last_end) last_end = c + L + n - 1;
      end
    end
    @(posedge clk);
    c++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, cur_cl, 1'b0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: state right after reset, checked by the first step
    tag = "R9";
    step(1'b0, 1'b0, 3'd3, 1'b0);
    // R1: single short read at minimum latency
    tag = "R1";
    step(1'b1, 1'b0, 3'd3, 1'b0);
    idle(14);
    // R2: burst of 8 gives four strobe cycles
    tag = "R2";
    step(1'b1, 1'b1, 3'd5, 1'b0);
    idle(14);
    // R4: latency changed while a read is outstanding
    tag = "R4";
    step(1'b1, 1'b1, 3'd6, 1'b0);
    step(1'b0, 1'b0, 3'd3, 1'b0);
    step(1'b0, 1'b0, 3'd3, 1'b0);
    idle(8);
    step(1'b1, 1'b0, 3'd3, 1'b0);
    idle(12);
    // R5: out-of-range latency clamped
    tag = "R5";
    step(1'b1, 1'b0, 3'd0, 1'b0);
    idle(12);
    step(1'b1, 1'b0, 3'd7, 1'b0);
    idle(14);
    // R6: back-to-back bursts of 8, then four stacked short reads
    tag = "R6";
    for (int i = 0; i < 4; i++) begin
      step(1'b1, 1'b1, 3'd4, 1'b0);
      step(1'b0, 1'b0, 3'd4, 1'b0);
      step(1'b0, 1'b0, 3'd4, 1'b0);
      step(1'b0, 1'b0, 3'd4, 1'b0);
    end
    idle(12);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 3'd6, 1'b0);
    idle(14);
    // R9: reset with reads still scheduled
    tag = "R9";
    step(1'b1, 1'b1, 3'd6, 1'b0);
    step(1'b1, 1'b0, 3'd3, 1'b0);
    step(1'b0, 1'b0, 3'd3, 1'b1);
    idle(12);
    // R1: random traffic
    tag = "R1";
    for (int i = 0; i < 2500; i++) begin
      if ($urandom % 16 == 0) cur_cl = 3'($urandom % 8);
      step(($urandom % 4) == 0, 1'($urandom), cur_cl, 1'b0);
    end
    idle(14);
    finish_run();
  end

endmodule